// File: doc/BRIEF.md
# Control-Plane Pixel Source Selector

This block scans out a mixed-depth framebuffer one pixel per clock. For every visible position it presents one pixel address to three planes of the same geometry: a byte-wide indexed plane, a 32-bit true-colour plane and a 32-bit control plane. A tag in the control word picks, per pixel, whether the output is the true-colour value or the indexed byte looked up in a 256-entry palette. Both depths can therefore appear side by side on the same screen.

A start pulse launches a frame of the configured visible width and height, at most 1024 by 768. Rows are laid out with a fixed stride of 1024 pixels whatever the visible width is, and columns past the visible width are never fetched. The planes are modelled as read ports with data returned in the same cycle as the address. The palette adds one register stage, and the true-colour path and the select bit are delayed to match it. Pixels leave through a valid/ready handshake that carries end-of-line and end-of-frame flags. Back-pressure stalls the scan without losing or repeating pixels.

Top module: `plane_pixel_selector`

## Requirements
- R1: During and after reset, outValid, busy and rdEn are low. Palette entries 0 to 254 hold black (0x000000) and entry 255 holds white (0xFFFFFF).
- R2: A start pulse while idle begins a frame at column 0, row 0. In the first cycle of busy, rdEn is high with rdAddr 0. Pixels then come out in raster order, left to right and then top to bottom.
- R3: A pixel whose control word has bits 31:24 equal to 0x03 takes its colour from the true-colour word. Any other tag value outputs the palette entry addressed by the indexed byte.
- R4: In a true-colour word, red is bits 7:0, green is bits 15:8 and blue is bits 23:16, and bits 31:24 are ignored. pixRgb and palData both carry red in 23:16, green in 15:8 and blue in 7:0.
- R5: The read address of column x in row y is y*1024 + x for any visible width, so column = rdAddr[9:0] and row = rdAddr[19:10]. No address with a column at or beyond the visible width, or a row at or beyond the visible height, is ever issued.
- R6: A frame delivers exactly width*height pixels. outEol is high on the last pixel of each row. outEof is high only on the very last pixel, which also carries outEol.
- R7: While outValid is high and outReady is low, outValid, pixRgb, outEol and outEof hold their values. No pixel is lost or duplicated under back-pressure.
- R8: busy rises in the cycle after an accepted start. It falls in the cycle after the end-of-frame pixel is accepted, and at that point outValid is low.
- R9: A start pulse is ignored while busy, together with the size inputs sampled with it. A start with a visible width or height of zero is also ignored and busy stays low.
- R10: A palette write (palWe high) stores palData into entry palAddr. Pixels fetched after the write cycle see the new colour.
- R11: The extremes of the supported size work: rows of full width 1024, and frames of full height 768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Frame start pulse |
| visW | input | 11 | Visible width in pixels (1..1024), sampled at start |
| visH | input | 10 | Visible height in rows (1..768), sampled at start |
| busy | output | 1 | Frame in progress, until the last pixel is accepted |
| rdEn | output | 1 | A pixel is fetched from the three planes this cycle |
| rdAddr | output | 20 | Pixel address, row*1024 + column |
| idxRd | input | 8 | Indexed-plane byte at rdAddr |
| dirRd | input | 32 | True-colour word at rdAddr |
| ctlRd | input | 32 | Control-plane word at rdAddr |
| palWe | input | 1 | Palette write strobe |
| palAddr | input | 8 | Palette entry to write |
| palData | input | 24 | Palette colour {red, green, blue} |
| outValid | output | 1 | Output pixel valid |
| outReady | input | 1 | Consumer accepts the pixel |
| outEol | output | 1 | Last pixel of a row |
| outEof | output | 1 | Last pixel of the frame |
| pixRgb | output | 24 | Output colour {red, green, blue} |

## Verification
A fetch made in one cycle appears on pixRgb after exactly one register stage. The cycle in which it leaves depends only on outReady, so the bench does not predict cycle numbers for pixel data. Instead it scores each pixel at its handshake, against a raster counter of its own and expected colours built from its own plane and palette models. Control outputs have fixed timing. busy and the first fetch at address 0 are due one edge after start, and busy drops one edge after the end-of-frame handshake. The bench samples these on the falling edge that follows. Ready changes just after each rising edge, so every falling-edge sample sees settled values.

// File: rtl/pixsel_pkg.sv
package pixsel_pkg;

  // Control-plane tag that selects the true-colour word.
  localparam logic [7:0] DIRECT_TAG = 8'h03;

  // Strobes from the scan control to the datapath.
  typedef struct packed {
    logic take;      // fetch the pixel at the current address
    logic lineEnd;   // fetched pixel closes a row
    logic frameEnd;  // fetched pixel closes the frame
  } scanStrobe_t;

endpackage

// File: rtl/pixsel_scan_ctrl.sv
module pixsel_scan_ctrl
  import pixsel_pkg::*;
#(
  parameter int MAX_W  = 1024,
  parameter int MAX_H  = 768,
  parameter int STRIDE = 1024,
  parameter int XW     = 11,
  parameter int YW     = 10,
  parameter int AW     = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [XW-1:0] visW,
  input  logic [YW-1:0] visH,
  input  logic          canTake,
  input  logic          pipeBusy,
  output scanStrobe_t   strb,
  output logic [AW-1:0] rdAddr,
  output logic          scanning
);

  logic [XW-1:0] xCnt, wLat;
  logic [YW-1:0] yCnt, hLat;
  logic lastCol, lastRow, startOk;

  assign lastCol = (xCnt == wLat - XW'(1));
  assign lastRow = (yCnt == hLat - YW'(1));
  assign startOk = start && !scanning && !pipeBusy &&
                   (visW != '0) && (visH != '0);

  always_comb begin
    strb.take     = scanning && canTake;
    strb.lineEnd  = lastCol;
    strb.frameEnd = lastCol && lastRow;
  end

  assign rdAddr = AW'(yCnt) * AW'(STRIDE) + AW'(xCnt);

  always_ff @(posedge clk) begin
    if (rst) begin
      scanning <= 1'b0;
      xCnt     <= '0;
      yCnt     <= '0;
      wLat     <= XW'(1);
      hLat     <= YW'(1);
    end else if (startOk) begin
      scanning <= 1'b1;
      xCnt     <= '0;
      yCnt     <= '0;
      wLat     <= visW;
      hLat     <= visH;
    end else if (strb.take) begin
      if (lastCol) begin
        xCnt <= '0;
        if (lastRow) begin
          scanning <= 1'b0;
          yCnt     <= '0;
        end else begin
          yCnt <= yCnt + YW'(1);
        end
      end else begin
        xCnt <= xCnt + XW'(1);
      end
    end
  end

endmodule

// File: rtl/pixsel_datapath.sv
module pixsel_datapath
  import pixsel_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int COL_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  scanStrobe_t        strb,
  input  logic [IDX_W-1:0]   idxRd,
  input  logic [4*COL_W-1:0] dirRd,
  input  logic [4*COL_W-1:0] ctlRd,
  input  logic               palWe,
  input  logic [IDX_W-1:0]   palAddr,
  input  logic [3*COL_W-1:0] palData,
  input  logic               outReady,
  output logic               canTake,
  output logic               outValid,
  output logic               outEol,
  output logic               outEof,
  output logic [3*COL_W-1:0] pixRgb
);

  localparam int PAL_N = 1 << IDX_W;
  localparam int RGB_W = 3 * COL_W;
  localparam int WRD_W = 4 * COL_W;
  localparam logic [RGB_W-1:0] WHITE = {RGB_W{1'b1}};

  logic [RGB_W-1:0] palMem [PAL_N];
  logic [RGB_W-1:0] palQ, dirQ, dirUnpacked;
  logic             selQ, isDirect;
  logic             unusedBits;

  assign unusedBits = ^{ctlRd[WRD_W-COL_W-1:0], dirRd[WRD_W-1:RGB_W]};

  // red from the low byte, blue from the third byte
  assign dirUnpacked = {dirRd[COL_W-1:0], dirRd[2*COL_W-1:COL_W],
                        dirRd[3*COL_W-1:2*COL_W]};
  assign isDirect = (ctlRd[WRD_W-1:WRD_W-COL_W] == COL_W'(DIRECT_TAG));
  assign canTake  = !outValid || outReady;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < PAL_N; i++) begin
        palMem[i] <= (i == PAL_N - 1) ? WHITE : '0;
      end
    end else if (palWe) begin
      palMem[palAddr] <= palData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      outEol   <= 1'b0;
      outEof   <= 1'b0;
      selQ     <= 1'b0;
      palQ     <= '0;
      dirQ     <= '0;
    end else if (canTake) begin
      outValid <= strb.take;
      if (strb.take) begin
        palQ   <= palMem[idxRd];
        dirQ   <= dirUnpacked;
        selQ   <= isDirect;
        outEol <= strb.lineEnd;
        outEof <= strb.frameEnd;
      end
    end
  end

  assign pixRgb = selQ ? dirQ : palQ;

endmodule

// File: rtl/plane_pixel_selector.sv
module plane_pixel_selector
  import pixsel_pkg::*;
#(
  parameter int MAX_W  = 1024,
  parameter int MAX_H  = 768,
  parameter int STRIDE = 1024,
  parameter int IDX_W  = 8,
  parameter int COL_W  = 8,
  localparam int XW    = $clog2(MAX_W + 1),
  localparam int YW    = $clog2(MAX_H + 1),
  localparam int AW    = $clog2(STRIDE * MAX_H)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [XW-1:0]      visW,
  input  logic [YW-1:0]      visH,
  output logic               busy,
  output logic               rdEn,
  output logic [AW-1:0]      rdAddr,
  input  logic [IDX_W-1:0]   idxRd,
  input  logic [4*COL_W-1:0] dirRd,
  input  logic [4*COL_W-1:0] ctlRd,
  input  logic               palWe,
  input  logic [IDX_W-1:0]   palAddr,
  input  logic [3*COL_W-1:0] palData,
  output logic               outValid,
  input  logic               outReady,
  output logic               outEol,
  output logic               outEof,
  output logic [3*COL_W-1:0] pixRgb
);

  scanStrobe_t strb;
  logic canTake, scanning;

  pixsel_scan_ctrl #(
    .MAX_W(MAX_W), .MAX_H(MAX_H), .STRIDE(STRIDE),
    .XW(XW), .YW(YW), .AW(AW)
  ) ctrl_i (
    .clk(clk), .rst(rst), .start(start), .visW(visW), .visH(visH),
    .canTake(canTake), .pipeBusy(outValid), .strb(strb),
    .rdAddr(rdAddr), .scanning(scanning)
  );

  pixsel_datapath #(.IDX_W(IDX_W), .COL_W(COL_W)) dp_i (
    .clk(clk), .rst(rst), .strb(strb), .idxRd(idxRd), .dirRd(dirRd),
    .ctlRd(ctlRd), .palWe(palWe), .palAddr(palAddr), .palData(palData),
    .outReady(outReady), .canTake(canTake), .outValid(outValid),
    .outEol(outEol), .outEof(outEof), .pixRgb(pixRgb)
  );

  assign rdEn = strb.take;
  assign busy = scanning || outValid;

endmodule

// File: rtl/plane_pixel_selector_chk.sv
module plane_pixel_selector_chk #(
  parameter int AW    = 20,
  parameter int RGB_W = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             busy,
  input logic             rdEn,
  input logic [AW-1:0]    rdAddr,
  input logic             outValid,
  input logic             outReady,
  input logic             outEol,
  input logic             outEof,
  input logic [RGB_W-1:0] pixRgb
);

  // R2
  frame_origin_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (rdEn && rdAddr == '0));

  // R6
  eof_has_eol_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && outEof) |-> outEol);

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=>
      (outValid && $stable(pixRgb) && $stable(outEol) && $stable(outEof)));

  // R8
  busy_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(outValid && outReady && outEof));

  // R9
  restart_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (start && busy && !(outValid && outReady && outEof)) |=> busy);

endmodule

bind plane_pixel_selector plane_pixel_selector_chk #(.AW(AW), .RGB_W(3*COL_W)) chk_i (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .rdEn(rdEn),
  .rdAddr(rdAddr), .outValid(outValid), .outReady(outReady),
  .outEol(outEol), .outEof(outEof), .pixRgb(pixRgb)
);

// File: tb/plane_pixel_selector_tb_top.sv
`timescale 1ns/1ps
module plane_pixel_selector_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [10:0] visW = 11'd1;
  logic [9:0]  visH = 10'd1;
  logic        busy, rdEn;
  logic [19:0] rdAddr;
  logic [7:0]  idxRd;
  logic [31:0] dirRd, ctlRd;
  logic        palWe = 1'b0;
  logic [7:0]  palAddr = '0;
  logic [23:0] palData = '0;
  logic        outValid, outEol, outEof;
  logic        outReady = 1'b1;
  logic [23:0] pixRgb;

  always #2 clk = ~clk;  // 250 MHz

  plane_pixel_selector dut_i (
    .clk(clk), .rst(rst), .start(start), .visW(visW), .visH(visH),
    .busy(busy), .rdEn(rdEn), .rdAddr(rdAddr), .idxRd(idxRd),
    .dirRd(dirRd), .ctlRd(ctlRd), .palWe(palWe), .palAddr(palAddr),
    .palData(palData), .outValid(outValid), .outReady(outReady),
    .outEol(outEol), .outEof(outEof), .pixRgb(pixRgb)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit finished = 0;

  logic [31:0] salt = 32'h1234_5678;
  int          memMode = 0;   // 0: hashed planes, 1: 255/0 index pattern
  int          readyMode = 0; // 0: always, 1: ~50%, 2: ~25%
  logic [23:0] palModel [256];

  int curW = 1, curH = 1, expX = 0, expY = 0, pixCnt = 0, eofSeen = 0;
  bit holdPrev = 0;
  logic [23:0] prevPix;
  logic prevEol, prevEof;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mixF(input logic [31:0] a);
    logic [31:0] h;
    h = (a ^ salt) * 32'h9E37_79B1;
    h = h ^ (h >> 15);
    h = h * 32'h85EB_CA6B;
    h = h ^ (h >> 13);
    return h;
  endfunction

  function automatic logic [7:0] idxF(input logic [31:0] a);
    logic [31:0] h;
    if (memMode == 1) return a[0] ? 8'd0 : 8'd255;
    h = mixF(a);
    return h[7:0];
  endfunction

  function automatic logic [31:0] ctlF(input logic [31:0] a);
    logic [31:0] h;
    logic [7:0]  tag;
    if (memMode == 1) return 32'h0;
    h = mixF(a + 32'h1234);
    case (h[2:0])
      3'd0, 3'd1, 3'd2: tag = 8'h03;
      3'd3: tag = 8'h02;
      3'd4: tag = 8'h13;
      3'd5: tag = 8'h83;
      3'd6: tag = 8'h00;
      default: tag = 8'h07;
    endcase
    return {tag, h[31:8]};
  endfunction

  function automatic logic [31:0] dirF(input logic [31:0] a);
    return mixF(a ^ 32'hA5A5_0000);
  endfunction

  // R3, R4: expected colour for a plane address
  function automatic logic [23:0] expRgb(input logic [31:0] a);
    logic [31:0] c, d;
    c = ctlF(a);
    if (c[31:24] == 8'h03) begin
      d = dirF(a);
      return {d[7:0], d[15:8], d[23:16]};
    end
    return palModel[idxF(a)];
  endfunction

  always @(rdAddr or salt or memMode) begin
    idxRd = idxF({12'b0, rdAddr});
    dirRd = dirF({12'b0, rdAddr});
    ctlRd = ctlF({12'b0, rdAddr});
  end

  always @(posedge clk) begin
    #1;
    case (readyMode)
      0: outReady = 1'b1;
      1: outReady = ($urandom % 2) == 0;
      default: outReady = ($urandom % 4) == 0;
    endcase
  end

  // Monitor at the falling edge
  always @(negedge clk) begin
    if (!rst) begin
      if (holdPrev) begin  // R7
        chk(outValid && pixRgb == prevPix && outEol == prevEol && outEof == prevEof,
            "R7 stalled pixel held", int'(pixRgb), int'(prevPix));
      end
      holdPrev = outValid && !outReady;
      prevPix = pixRgb; prevEol = outEol; prevEof = outEof;
      if (rdEn) begin  // R5
        chk(int'(rdAddr[9:0]) < curW && int'(rdAddr[19:10]) < curH,
            "R5 fetch inside visible area", int'(rdAddr), curW);
      end
      if (outValid && outReady) begin
        logic [31:0] a;
        bit eolE, eofE;
        if (pixCnt >= curW * curH) begin
          chk(0, "R6 extra pixel", pixCnt, curW * curH);
        end else begin
          a = 32'(expY * 1024 + expX);
          eolE = (expX == curW - 1);
          eofE = eolE && (expY == curH - 1);
          chk(pixRgb == expRgb(a), "R2/R3/R4 pixel colour", int'(pixRgb), int'(expRgb(a)));
          chk(outEol == eolE && outEof == eofE, "R6 eol/eof flags",
              int'({outEol, outEof}), int'({eolE, eofE}));
          if (eofE) eofSeen++;
          if (eolE) begin expX = 0; expY++; end else expX++;
          pixCnt++;
        end
      end
    end
  end

  task automatic writePal(input logic [7:0] a, input logic [23:0] c);
    @(negedge clk);
    palWe = 1'b1; palAddr = a; palData = c;
    @(negedge clk);
    palWe = 1'b0;
    palModel[a] = c;
  endtask

  task automatic runFrame(input int w, input int h, input int rmode, input bit midStart);
    curW = w; curH = h; expX = 0; expY = 0; pixCnt = 0; eofSeen = 0;
    readyMode = rmode;
    @(negedge clk);
    visW = 11'(w); visH = 10'(h); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R8 busy after start", int'(busy), 1);
    if (midStart) begin  // R9: a second start with other sizes must be ignored
      repeat (5) @(negedge clk);
      visW = 11'd3; visH = 10'd1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      visW = 11'(w); visH = 10'(h);
    end
    while (busy) @(negedge clk);
    chk(pixCnt == w * h, "R6 pixel count", pixCnt, w * h);
    chk(eofSeen == 1, "R6 single end of frame", eofSeen, 1);
    chk(outValid == 1'b0, "R8 idle after last pixel", int'(outValid), 0);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      finishRun();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) palModel[i] = (i == 255) ? 24'hFFFFFF : 24'h0;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(!outValid && !busy && !rdEn, "R1 outputs during reset",
        int'({outValid, busy, rdEn}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!outValid && !busy && !rdEn, "R1 outputs after reset",
        int'({outValid, busy, rdEn}), 0);

    // R1: reset palette seen through pixels 255 (white) and 0 (black)
    memMode = 1;
    runFrame(4, 2, 0, 0);

    // R9: zero sizes ignored
    @(negedge clk); visW = 11'd0; visH = 10'd4; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(!busy && !rdEn, "R9 zero width ignored", int'(busy), 0);
    @(negedge clk); visW = 11'd4; visH = 10'd0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(!busy && !rdEn, "R9 zero height ignored", int'(busy), 0);

    // R10: load whole palette with random colours
    for (int i = 0; i < 256; i++) writePal(8'(i), 24'($urandom));
    runFrame(6, 2, 1, 0);

    memMode = 0;
    salt = $urandom; runFrame(7, 3, 1, 0);
    salt = $urandom; runFrame(1, 1, 0, 0);
    salt = $urandom; runFrame(16, 4, 2, 1);   // R7 heavy stall, R9 restart
    salt = $urandom; runFrame(5, 5, 1, 1);
    salt = $urandom; runFrame(1024, 2, 1, 0); // R11 full width
    salt = $urandom; runFrame(1, 768, 0, 0);  // R11 full height

    // R10: overwrite the two entries used by the pattern frame
    memMode = 1;
    writePal(8'd255, 24'h12_34_56);
    writePal(8'd0, 24'hAB_CD_EF);
    runFrame(3, 3, 1, 0);

    repeat (4) @(negedge clk);
    finishRun();
  end

endmodule